// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Logic Array

This block is a two-plane logic array. Its function is set while the chip runs. A set of configuration registers, called the personality, defines the function. The AND plane has one row per product term. Each row combines a chosen subset of the logic inputs, and each of those inputs can enter the term in true or in inverted form. The OR plane connects each product row to any number of outputs, and each output is the OR of the rows connected to it.

A mode input picks the topology of the OR plane:

- **General mode:** any row can feed any output, so one product term can be shared by several outputs.
- **Fixed-group mode:** each output can use only its own group of rows. Connection bits that point outside that group have no effect.

The personality is loaded one row at a time through an addressed write port. The outputs are registered. A host loads a function such as a code converter, sets the mode, and then drives input vectors. Each result appears one clock after its input.

Top module: `pla_array`

## Requirements
- R1: Bits [2i+1:2i] of a row's AND word hold the cell for logic input bit i. Code 2'b01 requires the input to be 1. Code 2'b10 requires it to be 0. Code 2'b00 leaves the input out of the term.
- R2: A cell holding code 2'b11 forces that row's product term to 0 for every input vector.
- R3: A row whose cells all hold 2'b00 has a product term of 1 for every input vector.
- R4: Bit k of a row's OR word connects that row to output k. Output k is the OR of the product terms of its connected rows, and it is 0 when no row is connected.
- R5: In general mode (`pal_mode` = 0), one row may feed several outputs at the same time. Removing one of its connection bits changes only that one output.
- R6: In fixed-group mode (`pal_mode` = 1), output k uses only rows GROUP*k to GROUP*k+GROUP-1. Connection bits for other rows are ignored. GROUP is 4 by default.
- R7: `out_vec` is registered, so inputs sampled at clock edge t show up after edge t. A write with `cfg_we` = 1 at edge t loads row `cfg_row` and first affects the evaluation made at edge t+1.
- R8: Synchronous reset clears every AND and OR word and drives `out_vec` to 0. Every output then reads 0 until the array is programmed.
- R9: Take A = bit 2, B = bit 1 and C = bit 0, and load the five rows AB, B'C, AC', B'C' and A. The array must then give F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A on outputs 0 to 3.
- R10: Take A = bit 3 down to D = bit 0. A BCD-to-Gray personality must give W = A + BD + BC on out[3], X = BC' on out[2], Y = B + C on out[1] and Z = A'B'C'D + BCD + AD' + B'CD' on out[0]. This must hold in both modes when Z uses rows 0–3, Y uses rows 4–7, X uses rows 8–11 and W uses rows 12–15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pal_mode | input | 1 | 1 selects the fixed-group OR plane, 0 the general one |
| cfg_we | input | 1 | Personality write strobe |
| cfg_row | input | RW | Index of the product row to write |
| cfg_and | input | 2*N | AND-plane word for the row, two bits per input |
| cfg_or | input | M | OR-plane word for the row, one bit per output |
| in_vec | input | N | Logic inputs |
| out_vec | output | M | Registered outputs |

## Verification
Some behaviour is checked by the assertions on every cycle:

- A write lands in the addressed row, and the personality holds when no write occurs.
- Reset clears the personality and the outputs.
- No output rises unless some live, connected row is allowed to feed it in the current mode. This covers killed rows, unconnected outputs and out-of-group bits.
- An all-don't-care row that is allowed to feed an output drives that output high.

Other behaviour can only be shown by the bench scenarios. These are the correct value of each literal, the exact reference and code-converter functions over every input vector, the effect of a shared term and of removing one of its connections, and the one-cycle delay between a write and its effect.

// File: rtl/pla_pkg.sv
package pla_pkg;
   localparam int CELL_W = 2;

   typedef enum logic [CELL_W-1:0] {
      CELL_SKIP = 2'b00,
      CELL_TRUE = 2'b01,
      CELL_INV  = 2'b10,
      CELL_KILL = 2'b11
   } cell_e;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
   parameter int N  = 4,
   parameter int P  = 16,
   parameter int M  = 4,
   parameter int RW = 4
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  we,
   input  logic [RW-1:0]                         row,
   input  logic [pla_pkg::CELL_W*N-1:0]          and_word,
   input  logic [M-1:0]                          or_word,
   output logic [P-1:0][pla_pkg::CELL_W*N-1:0]   and_plane,
   output logic [P-1:0][M-1:0]                   or_plane
);
   always_ff @(posedge clk) begin
      if (rst) begin
         and_plane <= '0;
         or_plane  <= '0;
      end else if (we) begin
         for (int r = 0; r < P; r++) begin
            if (row == RW'(r)) begin
               and_plane[r] <= and_word;
               or_plane[r]  <= or_word;
            end
         end
      end
   end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int N = 4,
   parameter int P = 16
) (
   input  logic [N-1:0]                          in_vec,
   input  logic [P-1:0][pla_pkg::CELL_W*N-1:0]   and_plane,
   output logic [P-1:0]                          term
);
   import pla_pkg::*;

   for (genvar r = 0; r < P; r++) begin : g_row
      logic [N-1:0] lit_ok;
      for (genvar i = 0; i < N; i++) begin : g_cell
         cell_e code;
         assign code      = cell_e'(and_plane[r][CELL_W*i +: CELL_W]);
         assign lit_ok[i] = (code == CELL_SKIP)
                          | ((code == CELL_TRUE) &  in_vec[i])
                          | ((code == CELL_INV)  & ~in_vec[i]);
      end
      assign term[r] = &lit_ok;
   end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int P     = 16,
   parameter int M     = 4,
   parameter int GROUP = 4
) (
   input  logic                  pal_mode,
   input  logic [P-1:0]          term,
   input  logic [P-1:0][M-1:0]   or_plane,
   output logic [M-1:0]          sum
);
   for (genvar k = 0; k < M; k++) begin : g_out
      logic [P-1:0] col;
      logic         any_hit;
      logic         grp_hit;
      for (genvar r = 0; r < P; r++) begin : g_col
         assign col[r] = or_plane[r][k];
      end
      assign any_hit = |(term & col);
      assign grp_hit = |(term[GROUP*k +: GROUP] & col[GROUP*k +: GROUP]);
      assign sum[k]  = pal_mode ? grp_hit : any_hit;
   end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
   parameter int N     = 4,
   parameter int P     = 16,
   parameter int M     = 4,
   parameter int GROUP = 4,
   localparam int RW   = (P > 1) ? $clog2(P) : 1,
   localparam int AW   = pla_pkg::CELL_W * N
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          pal_mode,
   input  logic          cfg_we,
   input  logic [RW-1:0] cfg_row,
   input  logic [AW-1:0] cfg_and,
   input  logic [M-1:0]  cfg_or,
   input  logic [N-1:0]  in_vec,
   output logic [M-1:0]  out_vec
);
   if (N < 1) begin : g_bad_n
      $error("pla_array: N must be at least 1");
   end
   if (M < 1) begin : g_bad_m
      $error("pla_array: M must be at least 1");
   end
   if (GROUP < 1 || P < M * GROUP) begin : g_bad_group
      $error("pla_array: P must hold GROUP rows for every output");
   end

   logic [P-1:0][AW-1:0] and_plane;
   logic [P-1:0][M-1:0]  or_plane;
   logic [P-1:0]         term;
   logic [M-1:0]         sum;

   pla_cfg_store #(.N(N), .P(P), .M(M), .RW(RW)) u_store (
      .clk      (clk),
      .rst      (rst),
      .we       (cfg_we),
      .row      (cfg_row),
      .and_word (cfg_and),
      .or_word  (cfg_or),
      .and_plane(and_plane),
      .or_plane (or_plane)
   );

   pla_and_plane #(.N(N), .P(P)) u_and (
      .in_vec   (in_vec),
      .and_plane(and_plane),
      .term     (term)
   );

   pla_or_plane #(.P(P), .M(M), .GROUP(GROUP)) u_or (
      .pal_mode(pal_mode),
      .term    (term),
      .or_plane(or_plane),
      .sum     (sum)
   );

   always_ff @(posedge clk) begin
      if (rst) out_vec <= '0;
      else     out_vec <= sum;
   end
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
   parameter int N     = 4,
   parameter int P     = 16,
   parameter int M     = 4,
   parameter int GROUP = 4,
   parameter int RW    = 4
) (
   input logic                                 clk,
   input logic                                 rst,
   input logic                                 pal_mode,
   input logic                                 cfg_we,
   input logic [RW-1:0]                        cfg_row,
   input logic [pla_pkg::CELL_W*N-1:0]         cfg_and,
   input logic [M-1:0]                         cfg_or,
   input logic [M-1:0]                         out_vec,
   input logic [P-1:0][pla_pkg::CELL_W*N-1:0]  and_plane,
   input logic [P-1:0][M-1:0]                  or_plane
);
   logic [P-1:0] live;
   logic [P-1:0] blank;
   logic [M-1:0] may_rise;
   logic [M-1:0] must_rise;

   for (genvar r = 0; r < P; r++) begin : g_row
      logic [N-1:0] killed;
      for (genvar i = 0; i < N; i++) begin : g_cell
         assign killed[i] = &and_plane[r][pla_pkg::CELL_W*i +: pla_pkg::CELL_W];
      end
      assign live[r]  = ~|killed;
      assign blank[r] = (and_plane[r] == '0);
   end

   for (genvar k = 0; k < M; k++) begin : g_out
      logic [P-1:0] col;
      for (genvar r = 0; r < P; r++) begin : g_col
         assign col[r] = or_plane[r][k];
      end
      assign may_rise[k]  = pal_mode ? |(col[GROUP*k +: GROUP] & live[GROUP*k +: GROUP])
                                     : |(col & live);
      assign must_rise[k] = pal_mode ? |(col[GROUP*k +: GROUP] & blank[GROUP*k +: GROUP])
                                     : |(col & blank);
   end

   // R2, R4, R6: an output rises only if a live, connected, permitted row feeds it
   a_r4_unsourced_low: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_vec & ~$past(may_rise)) == '0);

   a_r3_blank_row_high: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ($past(must_rise) & ~out_vec) == '0);

   a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> (and_plane[$past(cfg_row)] == $past(cfg_and))
                 && (or_plane[$past(cfg_row)] == $past(cfg_or)));

   a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !cfg_we |=> $stable(and_plane) && $stable(or_plane));

   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (and_plane == '0) && (or_plane == '0) && (out_vec == '0));
endmodule

bind pla_array pla_array_chk #(.N(N), .P(P), .M(M), .GROUP(GROUP), .RW(RW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pal_mode (pal_mode),
   .cfg_we   (cfg_we),
   .cfg_row  (cfg_row),
   .cfg_and  (cfg_and),
   .cfg_or   (cfg_or),
   .out_vec  (out_vec),
   .and_plane(and_plane),
   .or_plane (or_plane)
);

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
   localparam int P = 16;
   localparam int G = 4;
   localparam logic [1:0] S = 2'b00, T = 2'b01, I = 2'b10, K = 2'b11;

   logic       clk = 1'b0;
   logic       rst;
   logic       pal_mode;
   logic       cfg_we;
   logic [3:0] cfg_row;
   logic [7:0] cfg_and;
   logic [3:0] cfg_or;
   logic [3:0] in_vec;
   logic [3:0] out_vec;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_and [P];
   logic [3:0] m_or  [P];

   pla_array dut (
      .clk(clk), .rst(rst), .pal_mode(pal_mode), .cfg_we(cfg_we),
      .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
      .in_vec(in_vec), .out_vec(out_vec)
   );

   always #2 clk = ~clk;

   function automatic logic [7:0] mk(logic [1:0] c3, logic [1:0] c2, logic [1:0] c1, logic [1:0] c0);
      return {c3, c2, c1, c0};
   endfunction

   function automatic logic [3:0] model(logic [3:0] v, logic pal);
      logic [3:0] res;
      res = '0;
      for (int r = 0; r < P; r++) begin
         logic t;
         t = 1'b1;
         for (int i = 0; i < 4; i++) begin
            case (m_and[r][2*i +: 2])
               T: t = t & v[i];
               I: t = t & ~v[i];
               K: t = 1'b0;
               default: ;
            endcase
         end
         for (int k = 0; k < 4; k++)
            if (m_or[r][k] && (!pal || (r / G) == k)) res[k] = res[k] | t;
      end
      return res;
   endfunction

   function automatic logic [3:0] ref_fn(logic [3:0] v);
      logic a, b, c;
      a = v[2]; b = v[1]; c = v[0];
      return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
   endfunction

   function automatic logic [3:0] gray_fn(logic [3:0] v);
      logic a, b, c, d;
      a = v[3]; b = v[2]; c = v[1]; d = v[0];
      return {a | (b & d) | (b & c), b & ~c, b | c,
              (~a & ~b & ~c & d) | (b & c & d) | (a & ~d) | (~b & c & ~d)};
   endfunction

   task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic wr(int r, logic [7:0] a, logic [3:0] o);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = r[3:0]; cfg_and = a; cfg_or = o;
      m_and[r] = a; m_or[r] = o;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_all();
      for (int r = 0; r < P; r++) wr(r, '0, '0);
   endtask

   task automatic apply(logic [3:0] v, output logic [3:0] got);
      @(negedge clk);
      in_vec = v;
      @(negedge clk);
      got = out_vec;
   endtask

   task automatic t_reset();
      logic [3:0] got;
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R8 out after reset", out_vec, 4'b0000);
      rst = 1'b0;
      for (int r = 0; r < P; r++) begin m_and[r] = '0; m_or[r] = '0; end
      for (int v = 0; v < 16; v++) begin
         apply(v[3:0], got);
         check("R8 unprogrammed output", got, 4'b0000);
      end
   endtask

   task automatic load_ref();
      clear_all();
      wr(0, mk(S, T, T, S), 4'b0110);
      wr(1, mk(S, S, I, T), 4'b1000);
      wr(2, mk(S, T, S, I), 4'b0010);
      wr(3, mk(S, S, I, I), 4'b0101);
      wr(4, mk(S, T, S, S), 4'b1001);
   endtask

   task automatic t_reference();
      logic [3:0] got;
      load_ref();
      pal_mode = 1'b0;
      for (int v = 0; v < 16; v++) begin
         apply(v[3:0], got);
         check("R9 reference functions", got, ref_fn(v[3:0]));
         check("R1 literal model", got, model(v[3:0], 1'b0));
      end
   endtask

   task automatic t_shared();
      logic [3:0] got;
      apply(4'b0111, got);
      check("R5 shared AB and A terms", got, 4'b1111);
      wr(0, mk(S, T, T, S), 4'b0010);
      apply(4'b0111, got);
      check("R5 one connection removed", got, 4'b1011);
   endtask

   task automatic load_gray();
      clear_all();
      wr(0,  mk(I, I, I, T), 4'b0001);
      wr(1,  mk(S, T, T, T), 4'b0001);
      wr(2,  mk(T, S, S, I), 4'b0001);
      wr(3,  mk(S, I, T, I), 4'b0001);
      wr(4,  mk(S, T, S, S), 4'b0010);
      wr(5,  mk(S, S, T, S), 4'b0010);
      wr(8,  mk(S, T, I, S), 4'b0100);
      wr(12, mk(T, S, S, S), 4'b1000);
      wr(13, mk(S, T, S, T), 4'b1000);
      wr(14, mk(S, T, T, S), 4'b1000);
   endtask

   task automatic t_gray();
      logic [3:0] got;
      load_gray();
      pal_mode = 1'b0;
      for (int v = 0; v < 16; v++) begin
         apply(v[3:0], got);
         check("R10 code converter general mode", got, gray_fn(v[3:0]));
      end
      pal_mode = 1'b1;
      for (int v = 0; v < 16; v++) begin
         apply(v[3:0], got);
         check("R10 code converter group mode", got, gray_fn(v[3:0]));
      end
   endtask

   task automatic t_pal_ignore();
      logic [3:0] got;
      wr(0, mk(I, I, I, T), 4'b1111);
      pal_mode = 1'b1;
      for (int v = 0; v < 16; v++) begin
         apply(v[3:0], got);
         check("R6 out-of-group bits ignored", got, gray_fn(v[3:0]));
      end
      pal_mode = 1'b0;
      apply(4'b0001, got);
      check("R6 same bits honoured in general mode", got, 4'b1111);
      apply(4'b1001, got);
      check("R5 general mode model", got, model(4'b1001, 1'b0));
   endtask

   task automatic t_cells();
      logic [3:0] got;
      clear_all();
      pal_mode = 1'b0;
      wr(5, mk(S, S, K, S), 4'b1111);
      for (int v = 0; v < 16; v++) begin
         apply(v[3:0], got);
         check("R2 killed row stays low", got, 4'b0000);
      end
      wr(5, mk(S, S, S, S), 4'b0010);
      for (int v = 0; v < 16; v += 5) begin
         apply(v[3:0], got);
         check("R3 blank row high, R4 unconnected low", got, 4'b0010);
      end
   endtask

   task automatic t_write_timing();
      logic [3:0] got;
      clear_all();
      pal_mode = 1'b0;
      apply(4'b0000, got);
      check("R7 before write", got, 4'b0000);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 4'd2; cfg_and = '0; cfg_or = 4'b0001;
      m_and[2] = '0; m_or[2] = 4'b0001;
      @(negedge clk);
      cfg_we = 1'b0;
      check("R7 write not yet in output", out_vec, 4'b0000);
      @(negedge clk);
      check("R7 write visible next cycle", out_vec, 4'b0001);
   endtask

   initial begin
      rst = 1'b1; pal_mode = 1'b0; cfg_we = 1'b0; cfg_row = '0;
      cfg_and = '0; cfg_or = '0; in_vec = '0;
      t_reset();
      t_reference();
      t_shared();
      t_gray();
      t_pal_ignore();
      t_cells();
      t_write_timing();
      load_ref();
      t_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule